// File: doc/BRIEF.md
# Non-Destructive Burst Memory Self-Test Engine

This block tests a single-port synchronous SRAM while the rest of the chip keeps using it. It does not take the memory offline for one long test session. Instead it runs many short bursts. Each burst claims a small window of W consecutive words and works through a fixed sequence of steps:

1. Copy the window's contents into a private buffer.
2. Write all-zeros and read them back.
3. Write all-ones and read them back.
4. Write the buffered contents back to the same words.

After each burst a persistent window pointer moves forward by W words. Many bursts therefore sweep the whole address space. When the sweep passes the last address, the pointer wraps to zero and the sweep starts again.

The block sits between a functional master and the memory. While no burst is running, the functional request goes straight through to the memory and the read data comes straight back. A burst may begin only in a cycle where the engine is enabled and there is no functional request. Once a burst has started it cannot be interrupted: a functional request that arrives during it is held off until the restore step has finished. Any read-back mismatch sets a sticky fail flag and captures the address of the first failure. A sticky done flag reports that a full sweep has completed. A one-cycle start pulse clears both flags and sends the pointer back to zero.

Top module: `nd_burst_mtest`

## Requirements
- R1: Once started, a burst holds the memory for exactly 6*W consecutive cycles (24 for W=4) and issues one memory access per cycle, in this order: W reads of the window, W writes of zero, W reads, W writes of all-ones, W reads, W writes of the data returned by the first W reads. Within each group the addresses run from base to base+W-1.
- R2: A burst starts in the cycle after a cycle where test_en is 1, fn_req is 0 and no burst is running. While fn_req stays high, no burst ever starts.
- R3: fn_gnt is 0 in every cycle of a burst. A functional request held during a burst is granted in the first cycle after the last restore write.
- R4: Outside a burst, the memory port carries the functional request unchanged. Read data reaches fn_rdata one cycle after a granted read.
- R5: After every burst, every memory word holds the value it held before that burst.
- R6: The first burst after reset or after a start pulse uses base 0. Each later burst uses the previous base plus W, modulo the memory depth.
- R7: A read-back value that differs from the pattern just written sets tst_fail. tst_fail stays set until the next start pulse. fail_addr holds the address of the first mismatch only.
- R8: tst_done becomes 1 when the burst whose base is DEPTH-W completes, and it stays set until the next start pulse. If the engine is still enabled, bursts continue from base 0.
- R9: A run_start pulse clears tst_fail, tst_done and fail_addr to 0 and sends the next burst to base 0.
- R10: While test_en is 0, no burst starts. Dropping test_en in the middle of a burst does not shorten that burst.
- R11: After reset, tst_busy, tst_fail, tst_done, fn_gnt and fail_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Allows new bursts to start |
| run_start | input | 1 | One-cycle pulse that clears status and rewinds the window pointer |
| fn_req | input | 1 | Functional access request |
| fn_we | input | 1 | Functional write (1) or read (0) |
| fn_addr | input | AW | Functional address |
| fn_wdata | input | DW | Functional write data |
| fn_gnt | output | 1 | Functional access accepted this cycle |
| fn_rdata | output | DW | Functional read data, one cycle after the granted read |
| mem_ce | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle latency |
| tst_busy | output | 1 | Burst in progress |
| tst_fail | output | 1 | Sticky mismatch flag |
| tst_done | output | 1 | Sticky full-sweep flag |
| fail_addr | output | AW | Address of the first mismatch |

## Verification
The assertions check the rules that hold in every cycle:
- no grant is given during a burst;
- the engine issues an access in every cycle of a burst;
- every burst lasts exactly 6*W cycles;
- a burst starts only after an idle, enabled cycle;
- the fail and done flags stay set until a start pulse clears them.

Some behaviour only the bench scenarios can show. The bench compares every engine access with its own sequence model: the order of accesses, the addresses, the base advancing and wrapping, and the restored data. It also compares the whole memory with a shadow copy after each burst, so lost functional data would be caught. Finally, it injects stuck bits to check that only the first failing address is captured.

// File: rtl/nd_burst_mtest.sv
module nd_burst_mtest #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int W  = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_en,
  input  logic          run_start,
  input  logic          fn_req,
  input  logic          fn_we,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  output logic          fn_gnt,
  output logic [DW-1:0] fn_rdata,
  output logic          mem_ce,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          tst_busy,
  output logic          tst_fail,
  output logic          tst_done,
  output logic [AW-1:0] fail_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int IW = $clog2(W);
  localparam logic [AW-1:0] LAST_BASE = AW'(DEPTH - W);
  localparam logic [AW-1:0] STEP = AW'(W);
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  typedef enum logic [2:0] {PH_SAVE, PH_WR0, PH_RD0, PH_WR1, PH_RD1, PH_RESTORE} phase_t;

  phase_t ph;
  logic busy, fail_q, done_q, ptr_clr, cap_v, chk_v;
  logic [IW-1:0] idx, cap_idx;
  logic [AW-1:0] base, chk_addr, fail_addr_q;
  logic [DW-1:0] chk_pat, eng_wdata;
  logic [DW-1:0] save_buf [W];

  wire go        = !busy && test_en && !fn_req;
  wire idx_last  = idx == LAST_IDX;
  wire burst_end = busy && ph == PH_RESTORE && idx_last;
  wire eng_rd    = ph == PH_SAVE || ph == PH_RD0 || ph == PH_RD1;
  wire [AW-1:0] eng_addr = base + AW'(idx);
  wire mismatch  = chk_v && mem_rdata != chk_pat;

  always_comb begin
    case (ph)
      PH_WR1:     eng_wdata = '1;
      PH_RESTORE: eng_wdata = save_buf[idx];
      default:    eng_wdata = '0;
    endcase
  end

  assign fn_gnt    = fn_req && !busy;
  assign fn_rdata  = mem_rdata;
  assign mem_ce    = busy || fn_req;
  assign mem_we    = busy ? !eng_rd : fn_we;
  assign mem_addr  = busy ? eng_addr : fn_addr;
  assign mem_wdata = busy ? eng_wdata : fn_wdata;
  assign tst_busy  = busy;
  assign tst_fail  = fail_q;
  assign tst_done  = done_q;
  assign fail_addr = fail_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= PH_SAVE;
      idx  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      ph   <= PH_SAVE;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx_last ? '0 : idx + 1'b1;
      if (idx_last) begin
        if (ph == PH_RESTORE) busy <= 1'b0;
        else ph <= phase_t'(ph + 3'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      ptr_clr <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (run_start && !busy) base <= '0;
      else if (burst_end) base <= (ptr_clr || run_start) ? '0 : base + STEP;

      if (burst_end) ptr_clr <= 1'b0;
      else if (run_start && busy) ptr_clr <= 1'b1;

      if (run_start) done_q <= 1'b0;
      else if (burst_end && !ptr_clr && base == LAST_BASE) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      chk_v    <= 1'b0;
      cap_idx  <= '0;
      chk_pat  <= '0;
      chk_addr <= '0;
    end else begin
      cap_v    <= busy && ph == PH_SAVE;
      chk_v    <= busy && (ph == PH_RD0 || ph == PH_RD1);
      cap_idx  <= idx;
      chk_pat  <= (ph == PH_RD1) ? '1 : '0;
      chk_addr <= eng_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_v) save_buf[cap_idx] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (run_start) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_q <= chk_addr;
    end
  end
endmodule

module nd_burst_mtest_chk #(
  parameter int W = 4
)(
  input logic clk,
  input logic rst_n,
  input logic test_en,
  input logic run_start,
  input logic fn_req,
  input logic fn_gnt,
  input logic mem_ce,
  input logic tst_busy,
  input logic tst_fail,
  input logic tst_done
);
  localparam int BL = 6 * W;
  localparam int LW = $clog2(BL + 1) + 1;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else run_len <= tst_busy ? run_len + 1'b1 : '0;
  end

  AST_NO_GNT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) tst_busy |-> !fn_gnt); // R3
  AST_ENGINE_DRIVES:   assert property (@(posedge clk) disable iff (!rst_n) tst_busy |-> mem_ce); // R1
  AST_BURST_LEN:       assert property (@(posedge clk) disable iff (!rst_n) $fell(tst_busy) |-> run_len == LW'(BL)); // R1
  AST_START_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) $rose(tst_busy) |-> $past(test_en && !fn_req)); // R2
  AST_FAIL_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) tst_fail && !run_start |=> tst_fail); // R7
  AST_DONE_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) tst_done && !run_start |=> tst_done); // R8
  AST_START_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n) run_start |=> !tst_fail && !tst_done); // R9
endmodule

bind nd_burst_mtest nd_burst_mtest_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .run_start(run_start),
  .fn_req(fn_req), .fn_gnt(fn_gnt), .mem_ce(mem_ce),
  .tst_busy(tst_busy), .tst_fail(tst_fail), .tst_done(tst_done)
);

// File: tb/nd_burst_mtest_test.sv
module nd_burst_mtest_test;
  localparam int AW = 5, DW = 8, W = 4;
  localparam int DEPTH = 1 << AW, BL = 6 * W, NWIN = DEPTH / W;

  logic clk = 0, rst_n = 0, test_en = 0, run_start = 0;
  logic fn_req = 0, fn_we = 0;
  logic [AW-1:0] fn_addr = '0;
  logic [DW-1:0] fn_wdata = '0;
  logic fn_gnt, mem_ce, mem_we, tst_busy, tst_fail, tst_done;
  logic [DW-1:0] fn_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, fail_addr;

  always #5 clk = ~clk;

  nd_burst_mtest #(.AW(AW), .DW(DW), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .run_start(run_start),
    .fn_req(fn_req), .fn_we(fn_we), .fn_addr(fn_addr), .fn_wdata(fn_wdata),
    .fn_gnt(fn_gnt), .fn_rdata(fn_rdata),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .tst_busy(tst_busy), .tst_fail(tst_fail), .tst_done(tst_done), .fail_addr(fail_addr)
  );

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic flt_en = 0;
  logic [DW-1:0] rd_q = '0;
  assign mem_rdata = rd_q;

  function automatic logic [DW-1:0] fmask(input logic [AW-1:0] a);
    if (!flt_en) return '0;
    if (a == AW'(13)) return 8'h10;
    if (a == AW'(20)) return 8'h01;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (mem_ce) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else rd_q <= mem[mem_addr] | fmask(mem_addr);
    end
  end

  int nchk = 0, nerr = 0;
  bit ended = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  endtask

  int sb = 0, bursts = 0;
  logic [AW-1:0] exp_base = '0;
  logic busy_d = 0;
  logic [DW-1:0] save_exp [W];

  always @(negedge clk) begin
    int p, i, bad;
    logic [AW-1:0] ea;
    logic [DW-1:0] ewd;
    #2;
    if (!rst_n) begin
      sb = 0; bursts = 0; exp_base = '0; busy_d = 0;
    end else begin
      if (run_start) begin exp_base = '0; bursts = 0; end
      if (tst_busy) begin
        p = sb / W; i = sb % W;
        ea = exp_base + AW'(i);
        if (sb >= 1 && sb <= W) save_exp[sb-1] = mem_rdata;
        if (p == 0 || p == 2 || p == 4)
          check("R1 R6 access", {mem_ce, mem_we, mem_addr}, {1'b1, 1'b0, ea});
        else begin
          ewd = (p == 1) ? 8'h00 : (p == 3) ? 8'hFF : save_exp[i];
          check("R1 R6 R5 write", {mem_ce, mem_we, mem_addr, mem_wdata}, {1'b1, 1'b1, ea, ewd});
        end
        sb++;
      end else if (busy_d) begin
        check("R1 length", sb, BL);
        sb = 0;
        bursts++;
        exp_base = exp_base + AW'(W);
        check("R8 done", tst_done, bursts >= NWIN);
        if (!flt_en) begin
          bad = 0;
          for (int a = 0; a < DEPTH; a++) if (mem[a] !== shadow[a]) bad++;
          check("R5 preserved", bad, 0);
        end
      end
      busy_d = tst_busy;
    end
  end

  task automatic fn_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    fn_req = 1; fn_we = we; fn_addr = a; fn_wdata = d;
    #1;
    while (!fn_gnt) begin @(negedge clk); #1; end
    @(posedge clk);
    if (we) shadow[a] = d;
    @(negedge clk);
    fn_req = 0; fn_we = 0;
    if (!we) check("R4 read data", fn_rdata, shadow[a]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tst_busy) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); run_start = 1;
    @(negedge clk); run_start = 0;
  endtask

  localparam logic [17:0] VEC [12] = '{
    {1'b1, 5'd3,  8'hA5, 4'd2}, {1'b0, 5'd3,  8'h00, 4'd0},
    {1'b1, 5'd0,  8'h5A, 4'd9}, {1'b0, 5'd1,  8'h00, 4'd1},
    {1'b1, 5'd31, 8'hC3, 4'd0}, {1'b0, 5'd31, 8'h00, 4'd7},
    {1'b0, 5'd0,  8'h00, 4'd3}, {1'b1, 5'd17, 8'h00, 4'd15},
    {1'b1, 5'd18, 8'hFF, 4'd4}, {1'b0, 5'd17, 8'h00, 4'd0},
    {1'b0, 5'd18, 8'h00, 4'd12}, {1'b0, 5'd9,  8'h00, 4'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = DW'(a * 37 + 5);
      shadow[a] = DW'(a * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check("R11 busy", tst_busy, 0);
    check("R11 fail", tst_fail, 0);
    check("R11 done", tst_done, 0);
    check("R11 gnt", fn_gnt, 0);
    check("R11 fail_addr", fail_addr, 0);
    rst_n = 1;

    test_en = 1;
    for (int v = 0; v < 12; v++) begin
      fn_op(VEC[v][17], VEC[v][16:12], VEC[v][11:4]);
      repeat (int'(VEC[v][3:0])) @(negedge clk);
    end

    test_en = 0;
    wait_idle();
    test_en = 1;
    @(negedge clk);
    check("R2 start timing", tst_busy, 1);
    fn_req = 1; fn_we = 0; fn_addr = 5; test_en = 0;
    n = 0;
    #1;
    while (tst_busy) begin n++; @(negedge clk); #1; end
    check("R1 hold length", n, BL);
    check("R3 grant after restore", fn_gnt, 1);
    @(posedge clk);
    @(negedge clk);
    fn_req = 0;
    check("R4 stalled read", fn_rdata, shadow[5]);

    wait_idle();
    fn_req = 1; fn_we = 0; fn_addr = 7;
    @(negedge clk);
    test_en = 1;
    n = 0;
    repeat (40) begin @(negedge clk); if (tst_busy) n++; end
    check("R2 no start while requested", n, 0);
    fn_req = 0; test_en = 0;

    wait_idle();
    n = 0;
    repeat (40) begin @(negedge clk); if (tst_busy) n++; end
    check("R10 disabled idle", n, 0);
    test_en = 1;
    @(negedge clk);
    while (!tst_busy) @(negedge clk);
    test_en = 0;
    n = 0;
    while (tst_busy) begin n++; @(negedge clk); end
    check("R10 burst completes", n, BL);
    n = 0;
    repeat (30) begin @(negedge clk); if (tst_busy) n++; end
    check("R10 no further burst", n, 0);

    pulse_start();
    check("R9 done cleared", tst_done, 0);
    test_en = 1;
    while (bursts < NWIN - 1) @(negedge clk);
    check("R8 not yet done", tst_done, 0);
    while (bursts < NWIN + 2) @(negedge clk);
    check("R8 done after sweep", tst_done, 1);
    check("R7 clean run", tst_fail, 0);
    test_en = 0;
    wait_idle();

    pulse_start();
    flt_en = 1;
    test_en = 1;
    while (bursts < 3) @(negedge clk);
    check("R7 no early fail", tst_fail, 0);
    while (!tst_done) @(negedge clk);
    check("R7 fail set", tst_fail, 1);
    check("R7 first address", fail_addr, 13);
    while (bursts < NWIN + 2) @(negedge clk);
    check("R7 fail sticky", tst_fail, 1);
    check("R7 address kept", fail_addr, 13);
    test_en = 0;
    wait_idle();
    flt_en = 0;
    for (int a = 0; a < DEPTH; a++) shadow[a] = mem[a];

    pulse_start();
    check("R9 fail cleared", tst_fail, 0);
    check("R9 fail_addr cleared", fail_addr, 0);
    check("R9 done cleared again", tst_done, 0);
    test_en = 1;
    while (bursts < 2) @(negedge clk);
    check("R9 clean after clear", tst_fail, 0);
    test_en = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule